// File: doc/BRIEF.md
# I2C Register Target with Subaddress Pointer

This block is an I2C target that gives a host on a two-wire bus access to a small register file held outside the block. It oversamples the SCL and SDA lines with the system clock, finds START and STOP conditions, and shifts in an address byte. It answers only to its own fixed 7-bit address (default 1101000). It pulls SDA low through an open-drain enable and never drives it high.

Inside a write transaction, the first data byte after the address loads an internal pointer. Every later byte is written to the register that the pointer selects. A read transaction returns the register at the pointer, so a host first writes the pointer and then reads, either after a repeated START or in a later transaction. The pointer advances by one after every data byte that is written or read.

A `backupExit` pulse marks the return from backup power. For a window sized from the clock frequency, any START that arrives is refused.

Top module: `i2cRegTarget`

## Requirements
- R1: START (SDA falls while SCL is high) begins address reception from any state, including in the middle of a transaction. STOP (SDA rises while SCL is high) returns the block to idle from any state.
- R2: The address byte is shifted in MSB first. Its last bit gives the direction: 0 for write, 1 for read.
- R3: Only bytes 0xD0 (write) and 0xD1 (read) are acknowledged, which is the 7-bit address 1101000. Every other byte, including the general call byte 0x00, is left unacknowledged, and the block stays silent until the next START or STOP.
- R4: An acknowledge holds `sdaOe` high (SDA pulled low) from the SCL fall after the eighth bit, through the high phase of the ninth clock. It is released after the ninth SCL fall.
- R5: `sdaOe` changes only while SCL is low.
- R6: In a write, the first data byte loads the pointer. Each later byte causes a single-cycle `regWrEn` pulse, with `regAddr` equal to the pointer and `regWrData` equal to the byte, and the pointer then advances by one.
- R7: A data byte takes effect only after all eight bits and the acknowledge clock have completed. A byte cut short by STOP writes nothing and leaves the pointer unchanged.
- R8: In a read, the register at the pointer is sent MSB first, and the pointer advances after each byte. A host ACK (SDA low on the ninth clock) continues with the next register. A host NACK makes the block release SDA and ignore SCL until STOP or START.
- R9: After a `backupExit` pulse, START is ignored for `LOCK_US` microseconds, counted as `CLK_HZ*LOCK_US/1e6` clock cycles. After that window, START is accepted again.
- R10: The pointer keeps its value across STOP, so a later read transaction starts at the register that an earlier write selected.
- R11: After reset, `sdaOe` is 0, `regWrEn` is 0 and `regAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| backupExit | input | 1 | Single-cycle pulse when main power returns |
| regAddr | output | AW | Register index (the pointer) |
| regWrEn | output | 1 | Single-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Contents of the register at `regAddr` |

## Verification
The hardest situation to reach from the ports is a byte that is cut short. The host clocks in only some bits of a data byte after the pointer byte and then issues STOP. The stimulus then reads the target register back to confirm that nothing landed.

A second hard case is the silent state after a host NACK. The bench clocks a whole extra byte with SDA released, expects to read all ones, and then confirms through `regAddr` that the pointer did not move.

The lockout window is reached by issuing START directly after a `backupExit` pulse. A second START is then issued once the window has elapsed.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK, ST_WAIT
  } tgtState_e;

  // events reported by the datapath to the control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
    logic byteDone;
    logic addrMatch;
    logic rwBit;
    logic locked;
  } busEvt_t;

  // strobes and levels from the control to the datapath
  typedef struct packed {
    logic clrBits;
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic ptrLoad;
    logic ptrInc;
    logic wrReg;
    logic ackDrive;
    logic txActive;
  } ctrlStb_t;

endpackage

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         CLK_HZ      = 50_000_000,
  parameter int         LOCK_US     = 60,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 backupExit,
  input  ctrlStb_t             stb,
  output busEvt_t              evt,
  output logic                 sdaOe,
  output logic [AW-1:0]        regAddr,
  output logic                 regWrEn,
  output logic [BYTE_BITS-1:0] regWrData,
  input  logic [BYTE_BITS-1:0] regRdData
);

  localparam longint LOCK_L      = (longint'(CLK_HZ) * longint'(LOCK_US)) / 64'd1000000;
  localparam int     LOCK_CYCLES = int'(LOCK_L);
  localparam int     LW          = ($clog2(LOCK_CYCLES + 1) < 1) ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam int     CW          = $clog2(BYTE_BITS + 1);

  // line index 1 = SCL, 0 = SDA
  logic [1:0] lineIn;
  logic [1:0] lineS;
  logic [1:0] lineD;
  assign lineIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[SYNC_STAGES-2:0], lineIn[g]};
    end
    assign lineS[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineD <= 2'b11;
    else       lineD <= lineS;
  end

  logic sclS, sdaS, sclD, sdaD;
  assign sclS = lineS[1];
  assign sdaS = lineS[0];
  assign sclD = lineD[1];
  assign sdaD = lineD[0];

  logic [BYTE_BITS-1:0] rxShift;
  logic [BYTE_BITS-1:0] txShift;
  logic [CW-1:0]        bitCnt;
  logic [AW-1:0]        ptr;
  logic [LW-1:0]        lockCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      bitCnt  <= '0;
      ptr     <= '0;
      lockCnt <= '0;
    end else begin
      if (stb.clrBits)      bitCnt <= '0;
      else if (stb.shiftRx) bitCnt <= bitCnt + CW'(1);

      if (stb.shiftRx) rxShift <= {rxShift[BYTE_BITS-2:0], sdaS};

      if (stb.loadTx)       txShift <= regRdData;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b1};

      if (stb.ptrLoad)     ptr <= rxShift[AW-1:0];
      else if (stb.ptrInc) ptr <= ptr + AW'(1);

      if (backupExit)        lockCnt <= LW'(LOCK_CYCLES);
      else if (lockCnt != 0) lockCnt <= lockCnt - LW'(1);
    end
  end

  always_comb begin
    evt.start     = sclS & sclD & sdaD & ~sdaS;
    evt.stop      = sclS & sclD & ~sdaD & sdaS;
    evt.sclRise   = sclS & ~sclD;
    evt.sclFall   = ~sclS & sclD;
    evt.sdaBit    = sdaS;
    evt.byteDone  = (bitCnt == CW'(BYTE_BITS));
    evt.addrMatch = (rxShift[BYTE_BITS-1:1] == DEV_ADDR);
    evt.rwBit     = rxShift[0];
    evt.locked    = (lockCnt != 0);
  end

  assign sdaOe     = stb.ackDrive | (stb.txActive & ~txShift[BYTE_BITS-1]);
  assign regAddr   = ptr;
  assign regWrEn   = stb.wrReg;
  assign regWrData = rxShift;

  AST_WR_FULL_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrReg |-> (bitCnt == CW'(BYTE_BITS))); // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS); // R5
  AST_LOCK_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    backupExit |=> evt.locked); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrInc && !stb.ptrLoad) |=> (ptr == $past(ptr) + AW'(1))); // R6

endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busEvt_t  evt,
  output ctrlStb_t stb
);

  tgtState_e stQ, stD;
  logic rwQ, rwD;
  logic firstQ, firstD;
  logic seenQ, seenD;
  logic nackQ, nackD;
  logic ackQ, ackD;
  logic txQ, txD;

  always_comb begin
    stD    = stQ;
    rwD    = rwQ;
    firstD = firstQ;
    seenD  = seenQ;
    nackD  = nackQ;
    ackD   = ackQ;
    txD    = txQ;
    stb    = '0;

    if (evt.stop) begin
      stD  = ST_IDLE;
      ackD = 1'b0;
      txD  = 1'b0;
    end else if (evt.start && !evt.locked) begin
      stD         = ST_ADDR;
      stb.clrBits = 1'b1;
      firstD      = 1'b1;
      ackD        = 1'b0;
      txD         = 1'b0;
    end else begin
      case (stQ)
        ST_ADDR: begin
          if (evt.sclRise && !evt.byteDone) stb.shiftRx = 1'b1;
          else if (evt.sclFall && evt.byteDone) begin
            if (evt.addrMatch) begin
              stD  = ST_AACK;
              ackD = 1'b1;
              rwD  = evt.rwBit;
            end else begin
              stD = ST_WAIT;
            end
          end
        end
        ST_AACK: begin
          if (evt.sclFall) begin
            ackD        = 1'b0;
            stb.clrBits = 1'b1;
            if (rwQ) begin
              stb.loadTx = 1'b1;
              txD        = 1'b1;
              stD        = ST_RBYTE;
            end else begin
              stD = ST_WBYTE;
            end
          end
        end
        ST_WBYTE: begin
          if (evt.sclRise && !evt.byteDone) stb.shiftRx = 1'b1;
          else if (evt.sclFall && evt.byteDone) begin
            ackD = 1'b1;
            stD  = ST_WACK;
          end
        end
        ST_WACK: begin
          if (evt.sclFall) begin
            ackD        = 1'b0;
            stb.clrBits = 1'b1;
            stD         = ST_WBYTE;
            if (firstQ) begin
              stb.ptrLoad = 1'b1;
              firstD      = 1'b0;
            end else begin
              stb.wrReg  = 1'b1;
              stb.ptrInc = 1'b1;
            end
          end
        end
        ST_RBYTE: begin
          if (evt.sclRise && !evt.byteDone) stb.shiftRx = 1'b1;
          else if (evt.sclFall) begin
            if (evt.byteDone) begin
              txD        = 1'b0;
              stb.ptrInc = 1'b1;
              seenD      = 1'b0;
              stD        = ST_RACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (evt.sclRise) begin
            seenD = 1'b1;
            nackD = evt.sdaBit;
          end else if (evt.sclFall && seenQ) begin
            stb.clrBits = 1'b1;
            if (nackQ) begin
              stD = ST_WAIT;
            end else begin
              stb.loadTx = 1'b1;
              txD        = 1'b1;
              stD        = ST_RBYTE;
            end
          end
        end
        default: ;
      endcase
    end

    stb.ackDrive = ackQ;
    stb.txActive = txQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      rwQ    <= 1'b0;
      firstQ <= 1'b0;
      seenQ  <= 1'b0;
      nackQ  <= 1'b0;
      ackQ   <= 1'b0;
      txQ    <= 1'b0;
    end else begin
      stQ    <= stD;
      rwQ    <= rwD;
      firstQ <= firstD;
      seenQ  <= seenD;
      nackQ  <= nackD;
      ackQ   <= ackD;
      txQ    <= txD;
    end
  end

  AST_ACK_OWN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_AACK) |-> evt.addrMatch); // R3
  AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE && evt.locked) |=> (stQ == ST_IDLE)); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> (stQ == ST_IDLE)); // R1
  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> (stQ == ST_AACK || stQ == ST_WACK)); // R4
  AST_SILENT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_WAIT) |-> (!ackQ && !txQ)); // R8

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         CLK_HZ      = 50_000_000,
  parameter int         LOCK_US     = 60,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic                 backupExit,
  output logic [AW-1:0]        regAddr,
  output logic                 regWrEn,
  output logic [BYTE_BITS-1:0] regWrData,
  input  logic [BYTE_BITS-1:0] regRdData
);

  busEvt_t  evt;
  ctrlStb_t stb;

  i2cTgtCtrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .evt  (evt),
    .stb  (stb)
  );

  i2cTgtData #(
    .DEV_ADDR    (DEV_ADDR),
    .CLK_HZ      (CLK_HZ),
    .LOCK_US     (LOCK_US),
    .AW          (AW),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .backupExit (backupExit),
    .stb        (stb),
    .evt        (evt),
    .sdaOe      (sdaOe),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/i2cRegTarget_test.sv
module i2cRegTarget_test;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2_000_000;
  localparam int LOCK_US    = 60;
  localparam int LOCK_CYC   = CLK_HZ / 1_000_000 * LOCK_US;
  localparam int Q          = 6;
  localparam int H          = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclH = 1'b1;
  logic sdaH = 1'b1;
  logic backupExit = 1'b0;
  logic sdaBus;
  logic sdaOe;
  logic [7:0] regAddr;
  logic regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  int checks = 0;
  int errors = 0;
  int r5Viol = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaBus = sdaH & ~sdaOe;

  i2cRegTarget #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclH),
    .sdaIn      (sdaBus),
    .sdaOe      (sdaOe),
    .backupExit (backupExit),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData)
  );

  // register file model outside the block
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end
  assign regRdData = mem[regAddr];

  logic [7:0] expMem [256];
  initial for (int i = 0; i < 256; i++) expMem[i] = 8'(i * 7 + 3);

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wrItem_t;
  wrItem_t expQ[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them (R6, R7)
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected write", {regAddr, regWrData}, 32'h0);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        chk(regAddr == it.a && regWrData == it.d, "R6 write", {regAddr, regWrData}, {it.a, it.d});
      end
    end
    if (rstN && sdaOe !== prevOe && sclH) r5Viol++;
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sdaH = 1'b1; tick(Q);
    sclH = 1'b1; tick(Q);
    sdaH = 1'b0; tick(Q);
    sclH = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    sdaH = 1'b0; tick(Q);
    sclH = 1'b1; tick(Q);
    sdaH = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic v);
    sdaH = v;    tick(Q);
    sclH = 1'b1; tick(H);
    sclH = 1'b0; tick(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaH = 1'b1; tick(Q);
    sclH = 1'b1; tick(H / 2);
    acked = (sdaBus == 1'b0);
    tick(H / 2);
    sclH = 1'b0; tick(Q);
  endtask

  task automatic readByte(output logic [7:0] b, input bit ackIt);
    for (int i = 7; i >= 0; i--) begin
      sdaH = 1'b1; tick(Q);
      sclH = 1'b1; tick(H / 2);
      b[i] = sdaBus;
      tick(H / 2);
      sclH = 1'b0; tick(Q);
    end
    sendBit(ackIt ? 1'b0 : 1'b1);
  endtask

  // driver: writes a data byte and queues the expected register write
  task automatic putData(input logic [7:0] ptr, input logic [7:0] d, output bit acked);
    expQ.push_back({ptr, d});
    expMem[ptr] = d;
    writeByte(d, acked);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;

    tick(5);
    // R11: reset state
    chk(sdaOe == 1'b0, "R11 sdaOe", 32'(sdaOe), 0);
    chk(regWrEn == 1'b0, "R11 regWrEn", 32'(regWrEn), 0);
    chk(regAddr == 8'h00, "R11 regAddr", 32'(regAddr), 0);
    rstN = 1'b1;
    tick(5);

    // R2/R3/R4: write transaction, pointer then two data bytes
    startCond();
    writeByte(8'hD0, ak);
    chk(ak, "R3 ack D0", 32'(ak), 1);
    chk(sdaOe == 1'b0, "R4 ack released", 32'(sdaOe), 0);
    writeByte(8'h10, ak);
    chk(ak, "R6 pointer byte ack", 32'(ak), 1);
    putData(8'h10, 8'h3C, ak);
    chk(ak, "R6 data ack", 32'(ak), 1);
    putData(8'h11, 8'h7E, ak);
    chk(ak, "R6 data ack", 32'(ak), 1);
    stopCond();
    chk(regAddr == 8'h12, "R6 pointer advanced", 32'(regAddr), 32'h12);

    // R1/R8: pointer write, repeated start, read three bytes
    startCond();
    writeByte(8'hD0, ak);
    writeByte(8'h10, ak);
    startCond();
    writeByte(8'hD1, ak);
    chk(ak, "R3 ack D1 after repeated start R1", 32'(ak), 1);
    readByte(rb, 1'b1);
    chk(rb == expMem[8'h10], "R8 read byte0", 32'(rb), 32'(expMem[8'h10]));
    readByte(rb, 1'b1);
    chk(rb == expMem[8'h11], "R8 read byte1", 32'(rb), 32'(expMem[8'h11]));
    readByte(rb, 1'b0);
    chk(rb == expMem[8'h12], "R8 read byte2", 32'(rb), 32'(expMem[8'h12]));
    stopCond();

    // R10: pointer persists into a fresh read transaction
    startCond();
    writeByte(8'hD1, ak);
    readByte(rb, 1'b0);
    chk(rb == expMem[8'h13], "R10 persisted pointer", 32'(rb), 32'(expMem[8'h13]));
    stopCond();
    chk(regAddr == 8'h14, "R10 pointer", 32'(regAddr), 32'h14);

    // R3: foreign address, and a byte after it is ignored
    startCond();
    writeByte(8'hA0, ak);
    chk(!ak, "R3 no ack A0", 32'(ak), 0);
    writeByte(8'h55, ak);
    chk(!ak, "R3 silent after foreign addr", 32'(ak), 0);
    stopCond();
    chk(regAddr == 8'h14, "R3 pointer untouched", 32'(regAddr), 32'h14);

    // R3: general call
    startCond();
    writeByte(8'h00, ak);
    chk(!ak, "R3 general call", 32'(ak), 0);
    stopCond();

    // R3: neighbour address; R2: bit-reversed own address
    startCond();
    writeByte(8'hD2, ak);
    chk(!ak, "R3 no ack D2", 32'(ak), 0);
    stopCond();
    startCond();
    writeByte(8'h0B, ak);
    chk(!ak, "R2 msb first", 32'(ak), 0);
    stopCond();

    // R7: pointer 0x20, then a byte cut short by STOP
    startCond();
    writeByte(8'hD0, ak);
    writeByte(8'h20, ak);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    stopCond();
    chk(regAddr == 8'h20, "R7 pointer unchanged by partial byte", 32'(regAddr), 32'h20);
    startCond();
    writeByte(8'hD1, ak);
    readByte(rb, 1'b0);
    chk(rb == expMem[8'h20], "R7 register unchanged", 32'(rb), 32'(expMem[8'h20]));

    // R8: after NACK the block stays silent and the pointer holds
    readByte(rb, 1'b0);
    chk(rb == 8'hFF, "R8 silent after nack", 32'(rb), 32'hFF);
    stopCond();
    chk(regAddr == 8'h21, "R8 pointer holds after nack", 32'(regAddr), 32'h21);

    // R9: START refused during lockout, accepted afterwards
    backupExit = 1'b1; tick(1);
    backupExit = 1'b0;
    startCond();
    writeByte(8'hD0, ak);
    chk(!ak, "R9 start refused in lockout", 32'(ak), 0);
    stopCond();
    tick(LOCK_CYC);
    startCond();
    writeByte(8'hD0, ak);
    chk(ak, "R9 start accepted after lockout", 32'(ak), 1);
    stopCond();

    tick(20);
    chk(expQ.size() == 0, "R6 all writes seen", 32'(expQ.size()), 0);
    chk(r5Viol == 0, "R5 sdaOe moves only with SCL low", 32'(r5Viol), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule